// File: doc/BRIEF.md
# Cross-Call Scheduler for Processor and Hardware Compute Units

This block decides which agent runs in a system made of one host processor and a set of hardware compute units. At any moment only one agent is active. That agent is either the processor or exactly one unit. Both sides can start calls. The processor starts a unit by writing a call command. A unit can call another unit, call itself recursively, or call back into software. For each call the block saves the identity of the caller on a small return stack. When the callee finishes, the block resumes the caller that was saved most recently. Calls can therefore nest and cross between software and hardware to any depth the stack allows.

The processor sees a small register window: a command register, a status register, a stack pointer, a read-only link register and a bank of argument registers. The units see the same argument and stack-pointer values on broadcast buses. The active unit can write those registers through a shared write port. Each unit has a level enable, a finish pulse, and a call-request pulse. The call request carries a target ID and a flag that says whether the target is hardware or software. Hardware IDs run from 1 to the number of units, where unit i has ID i+1. ID 0 names the processor. Software callee IDs are a separate number space and are handed to the processor through the status register. A single interrupt line tells the processor that a unit returned to it or that a unit wants a software routine run.

Top module: `xcall_ctrl`

## Requirements
- R1: After reset no unit is enabled, the interrupt is low, the status, link and stack-pointer registers read 0, and the processor is the active agent.
- R2: While the processor is active, writing the command register with op 1 in bits [1:0] and a valid hardware ID in bits [15:8] enables that unit from the next clock edge and disables the processor role.
- R3: When the active unit raises a software call request, the unit is disabled on the next edge and the interrupt is raised. The status reads cause 2 in bits [1:0] and the software ID in bits [15:8].
- R4: While the processor is active and a suspended unit is waiting on software, writing the command register with op 2 re-enables that unit on the next edge.
- R5: A call request from the active unit with a valid hardware target enables the target on the very next edge, without raising the interrupt. When the target finishes, the caller is re-enabled on the next edge. Both dispatch and return take one cycle.
- R6: Callers resume in last-in, first-out order across any mix of hardware and software calls, including recursive calls. The link register (address 3) reads the most recently saved caller ID, with 0 meaning the processor.
- R7: The return stack holds STACK_DEPTH caller IDs. A call made while it is full is ignored, and the call sets the overflow flag in status bit 2. The flag stays set until cleared.
- R8: When a unit that was called from the processor finishes, the unit is disabled and the interrupt is raised, with cause 1 and the finished unit's hardware ID in bits [15:8]. The interrupt stays high until the processor writes the status register with bit 0 set. Writing bit 2 clears the overflow flag.
- R9: The following are ignored: finish or call requests from units that are not enabled, command writes while a unit is active, hardware IDs of 0 or above the unit count, and op 2 when no unit is waiting on software.
- R10: The stack pointer (address 2) and the argument registers (addresses 4 and up) accept processor writes only while the processor is active. They accept unit-port writes only while a unit is active. Their values appear on the broadcast outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Processor register write strobe |
| hostAddr | input | ADDR_W | Processor register address |
| hostWrData | input | DATA_W | Processor write data |
| hostRdData | output | DATA_W | Processor read data for hostAddr |
| irq | output | 1 | Interrupt to the processor |
| unitEn | output | NUM_UNITS | Per-unit enable, at most one high |
| unitFinish | input | NUM_UNITS | Per-unit finish pulse |
| unitCallReq | input | NUM_UNITS | Per-unit call request pulse |
| unitCallHw | input | NUM_UNITS | Call target is hardware (1) or software (0) |
| unitCallId | input | NUM_UNITS*CALL_ID_W | Per-unit call target ID |
| unitRegWrEn | input | 1 | Active unit's register write strobe |
| unitRegIdx | input | ADDR_W | Register address for the unit write |
| unitRegWrData | input | DATA_W | Unit write data |
| argBus | output | NUM_ARGS*DATA_W | Argument register contents |
| spOut | output | DATA_W | Stack pointer contents |

## Verification
The properties assume that each unit pulses finish or call request for a single cycle, and only while it is enabled. They also assume the processor follows the command protocol. A stray pulse from an idle unit is still allowed and must leave the state untouched. The bench drives every pulse for exactly one cycle between falling edges. It raises unit inputs only on the unit whose behaviour is under test, except in the scenario that deliberately fires inactive units. It never makes a unit finish and call in the same cycle.

// File: rtl/xcall_pkg.sv
package xcall_pkg;

  // register window offsets (processor side)
  localparam int ADDR_CMD    = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_SP     = 2;
  localparam int ADDR_LR     = 3;
  localparam int ADDR_ARG0   = 4;

  // command ops in bits [1:0] of a command write
  localparam logic [1:0] OP_CALL   = 2'd1;
  localparam logic [1:0] OP_SWDONE = 2'd2;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_HWDONE = 2'd1,
    CAUSE_SWCALL = 2'd2
  } cause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   push;
    logic   pop;
    logic   load;
    logic   raiseIrq;
    cause_t cause;
    logic   clrIrq;
    logic   setOvf;
    logic   clrOvf;
    logic   regWr;
    logic   regFromHost;
  } ctrlStrobe_t;

endpackage

// File: rtl/xcall_control.sv
module xcall_control
  import xcall_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int NUM_ARGS  = 4,
  parameter int CALL_ID_W = 8,
  parameter int HW_ID_W   = 3,
  parameter int ADDR_W    = 3
) (
  input  logic                           hostWrEn,
  input  logic [ADDR_W-1:0]              hostAddr,
  input  logic [2:0]                     hostCtl,
  input  logic [CALL_ID_W-1:0]           hostCmdId,
  input  logic [NUM_UNITS-1:0]           unitFinish,
  input  logic [NUM_UNITS-1:0]           unitCallReq,
  input  logic [NUM_UNITS-1:0]           unitCallHw,
  input  logic [NUM_UNITS*CALL_ID_W-1:0] unitCallId,
  input  logic                           unitRegWrEn,
  input  logic [ADDR_W-1:0]              unitRegIdx,
  input  logic [HW_ID_W-1:0]             curId,
  input  logic                           stkFull,
  input  logic                           stkEmpty,
  input  logic [HW_ID_W-1:0]             stkTop,
  output ctrlStrobe_t                    st,
  output logic [HW_ID_W-1:0]             pushId,
  output logic [HW_ID_W-1:0]             nextCur,
  output logic [CALL_ID_W-1:0]           statId
);

  logic                 procActive;
  logic                 actFin;
  logic                 actReq;
  logic                 actHw;
  logic [CALL_ID_W-1:0] actId;
  logic                 hostCmd;
  logic                 hostStat;

  function automatic logic isHwId(input logic [CALL_ID_W-1:0] id);
    return (id != '0) && (id <= CALL_ID_W'(NUM_UNITS));
  endfunction

  function automatic logic isDataReg(input logic [ADDR_W-1:0] a);
    int unsigned v;
    v = a;
    return (v == ADDR_SP) || ((v >= ADDR_ARG0) && (v < ADDR_ARG0 + NUM_ARGS));
  endfunction

  assign procActive = (curId == '0);
  assign hostCmd    = hostWrEn && (hostAddr == ADDR_W'(ADDR_CMD)) && procActive;
  assign hostStat   = hostWrEn && (hostAddr == ADDR_W'(ADDR_STATUS));

  // pick the inputs of the unit that currently holds the enable
  always_comb begin
    actFin = 1'b0;
    actReq = 1'b0;
    actHw  = 1'b0;
    actId  = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (curId == HW_ID_W'(i + 1)) begin
        actFin = unitFinish[i];
        actReq = unitCallReq[i];
        actHw  = unitCallHw[i];
        actId  = unitCallId[i*CALL_ID_W +: CALL_ID_W];
      end
    end
  end

  always_comb begin
    st      = '0;
    pushId  = '0;
    nextCur = '0;
    statId  = '0;

    if (actFin) begin
      if (!stkEmpty) begin
        st.pop  = 1'b1;
        st.load = 1'b1;
        nextCur = stkTop;
        if (stkTop == '0) begin
          st.raiseIrq = 1'b1;
          st.cause    = CAUSE_HWDONE;
          statId      = CALL_ID_W'(curId);
        end
      end
    end else if (actReq) begin
      if (actHw && !isHwId(actId)) begin
        st.load = 1'b0;
      end else if (stkFull) begin
        st.setOvf = 1'b1;
      end else begin
        st.push = 1'b1;
        st.load = 1'b1;
        pushId  = curId;
        if (actHw) begin
          nextCur = actId[HW_ID_W-1:0];
        end else begin
          nextCur     = '0;
          st.raiseIrq = 1'b1;
          st.cause    = CAUSE_SWCALL;
          statId      = actId;
        end
      end
    end else if (hostCmd && hostCtl[1:0] == OP_CALL) begin
      if (isHwId(hostCmdId)) begin
        if (stkFull) begin
          st.setOvf = 1'b1;
        end else begin
          st.push = 1'b1;
          st.load = 1'b1;
          pushId  = '0;
          nextCur = hostCmdId[HW_ID_W-1:0];
        end
      end
    end else if (hostCmd && hostCtl[1:0] == OP_SWDONE) begin
      if (!stkEmpty && stkTop != '0) begin
        st.pop  = 1'b1;
        st.load = 1'b1;
        nextCur = stkTop;
      end
    end

    st.clrIrq = hostStat && hostCtl[0];
    st.clrOvf = hostStat && hostCtl[2];

    if (hostWrEn && procActive && isDataReg(hostAddr)) begin
      st.regWr       = 1'b1;
      st.regFromHost = 1'b1;
    end else if (unitRegWrEn && !procActive && isDataReg(unitRegIdx)) begin
      st.regWr       = 1'b1;
      st.regFromHost = 1'b0;
    end
  end

endmodule

// File: rtl/xcall_datapath.sv
module xcall_datapath
  import xcall_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int NUM_ARGS    = 4,
  parameter int DATA_W      = 32,
  parameter int CALL_ID_W   = 8,
  parameter int STACK_DEPTH = 4,
  parameter int HW_ID_W     = 3,
  parameter int ADDR_W      = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 st,
  input  logic [HW_ID_W-1:0]          pushId,
  input  logic [HW_ID_W-1:0]          nextCur,
  input  logic [CALL_ID_W-1:0]        statId,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWrData,
  input  logic [ADDR_W-1:0]           unitRegIdx,
  input  logic [DATA_W-1:0]           unitRegWrData,
  output logic [HW_ID_W-1:0]          curId,
  output logic                        stkFull,
  output logic                        stkEmpty,
  output logic [HW_ID_W-1:0]          stkTop,
  output logic [DATA_W-1:0]           hostRdData,
  output logic                        irq,
  output logic [NUM_UNITS-1:0]        unitEn,
  output logic [NUM_ARGS*DATA_W-1:0]  argBus,
  output logic [DATA_W-1:0]           spOut
);

  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [HW_ID_W-1:0]   stkMem [STACK_DEPTH];
  logic [CNT_W-1:0]     stkCnt;
  logic [IDX_W-1:0]     topIdx;
  logic [HW_ID_W-1:0]   curIdQ;
  logic                 irqQ;
  cause_t               causeQ;
  logic [CALL_ID_W-1:0] statIdQ;
  logic                 ovfQ;
  logic [DATA_W-1:0]    argQ [NUM_ARGS];
  logic [DATA_W-1:0]    spQ;
  logic [ADDR_W-1:0]    wrIdx;
  logic [DATA_W-1:0]    wrData;

  // ---------------- caller return stack ----------------
  assign stkEmpty = (stkCnt == '0);
  assign stkFull  = (stkCnt == CNT_W'(STACK_DEPTH));
  assign topIdx   = IDX_W'(stkCnt - CNT_W'(1));
  assign stkTop   = stkEmpty ? '0 : stkMem[topIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stkCnt <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) stkMem[k] <= '0;
    end else begin
      if (st.push) begin
        for (int k = 0; k < STACK_DEPTH; k++)
          if (stkCnt == CNT_W'(k)) stkMem[k] <= pushId;
        stkCnt <= stkCnt + CNT_W'(1);
      end else if (st.pop) begin
        stkCnt <= stkCnt - CNT_W'(1);
      end
    end
  end

  // ---------------- active agent ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curIdQ <= '0;
    else if (st.load) curIdQ <= nextCur;
  end

  assign curId = curIdQ;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_en
    assign unitEn[g] = (curIdQ == HW_ID_W'(g + 1));
  end

  // ---------------- interrupt and status ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ    <= 1'b0;
      causeQ  <= CAUSE_NONE;
      statIdQ <= '0;
    end else if (st.raiseIrq) begin
      irqQ    <= 1'b1;
      causeQ  <= st.cause;
      statIdQ <= statId;
    end else if (st.clrIrq) begin
      irqQ   <= 1'b0;
      causeQ <= CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfQ <= 1'b0;
    else if (st.setOvf) ovfQ <= 1'b1;
    else if (st.clrOvf) ovfQ <= 1'b0;
  end

  assign irq = irqQ;

  // ---------------- shared call registers ----------------
  assign wrIdx  = st.regFromHost ? hostAddr : unitRegIdx;
  assign wrData = st.regFromHost ? hostWrData : unitRegWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ <= '0;
      for (int k = 0; k < NUM_ARGS; k++) argQ[k] <= '0;
    end else if (st.regWr) begin
      if (wrIdx == ADDR_W'(ADDR_SP)) spQ <= wrData;
      for (int k = 0; k < NUM_ARGS; k++)
        if (wrIdx == ADDR_W'(ADDR_ARG0 + k)) argQ[k] <= wrData;
    end
  end

  assign spOut = spQ;

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
    assign argBus[g*DATA_W +: DATA_W] = argQ[g];
  end

  // ---------------- processor read mux ----------------
  always_comb begin
    hostRdData = '0;
    if (hostAddr == ADDR_W'(ADDR_STATUS)) begin
      hostRdData[1:0]             = causeQ;
      hostRdData[2]               = ovfQ;
      hostRdData[8 +: CALL_ID_W]  = statIdQ;
    end else if (hostAddr == ADDR_W'(ADDR_SP)) begin
      hostRdData = spQ;
    end else if (hostAddr == ADDR_W'(ADDR_LR)) begin
      hostRdData[HW_ID_W-1:0] = stkTop;
    end else begin
      for (int k = 0; k < NUM_ARGS; k++)
        if (hostAddr == ADDR_W'(ADDR_ARG0 + k)) hostRdData = argQ[k];
    end
  end

  // ---------------- assertions ----------------
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irqQ && !st.clrIrq |=> irqQ); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ && !st.clrOvf |=> ovfQ); // R7

  AST_STACK_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    stkCnt <= CNT_W'(STACK_DEPTH)); // R7

  AST_CALLER_SAVED: assert property (@(posedge clk) disable iff (!rstN)
    curIdQ != '0 |-> stkCnt != '0); // R6

endmodule

// File: rtl/xcall_ctrl.sv
module xcall_ctrl
  import xcall_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int NUM_ARGS    = 4,
  parameter int DATA_W      = 32,
  parameter int CALL_ID_W   = 8,
  parameter int STACK_DEPTH = 4,
  localparam int HW_ID_W    = $clog2(NUM_UNITS + 1),
  localparam int ADDR_W     = $clog2(ADDR_ARG0 + NUM_ARGS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           hostWrEn,
  input  logic [ADDR_W-1:0]              hostAddr,
  input  logic [DATA_W-1:0]              hostWrData,
  output logic [DATA_W-1:0]              hostRdData,
  output logic                           irq,
  output logic [NUM_UNITS-1:0]           unitEn,
  input  logic [NUM_UNITS-1:0]           unitFinish,
  input  logic [NUM_UNITS-1:0]           unitCallReq,
  input  logic [NUM_UNITS-1:0]           unitCallHw,
  input  logic [NUM_UNITS*CALL_ID_W-1:0] unitCallId,
  input  logic                           unitRegWrEn,
  input  logic [ADDR_W-1:0]              unitRegIdx,
  input  logic [DATA_W-1:0]              unitRegWrData,
  output logic [NUM_ARGS*DATA_W-1:0]     argBus,
  output logic [DATA_W-1:0]              spOut
);

  ctrlStrobe_t        st;
  logic [HW_ID_W-1:0] pushId;
  logic [HW_ID_W-1:0] nextCur;
  logic [CALL_ID_W-1:0] statId;
  logic [HW_ID_W-1:0] curId;
  logic               stkFull;
  logic               stkEmpty;
  logic [HW_ID_W-1:0] stkTop;

  xcall_control #(
    .NUM_UNITS(NUM_UNITS), .NUM_ARGS(NUM_ARGS), .CALL_ID_W(CALL_ID_W),
    .HW_ID_W(HW_ID_W), .ADDR_W(ADDR_W)
  ) i_control (
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostCtl    (hostWrData[2:0]),
    .hostCmdId  (hostWrData[8 +: CALL_ID_W]),
    .unitFinish (unitFinish),
    .unitCallReq(unitCallReq),
    .unitCallHw (unitCallHw),
    .unitCallId (unitCallId),
    .unitRegWrEn(unitRegWrEn),
    .unitRegIdx (unitRegIdx),
    .curId      (curId),
    .stkFull    (stkFull),
    .stkEmpty   (stkEmpty),
    .stkTop     (stkTop),
    .st         (st),
    .pushId     (pushId),
    .nextCur    (nextCur),
    .statId     (statId)
  );

  xcall_datapath #(
    .NUM_UNITS(NUM_UNITS), .NUM_ARGS(NUM_ARGS), .DATA_W(DATA_W),
    .CALL_ID_W(CALL_ID_W), .STACK_DEPTH(STACK_DEPTH),
    .HW_ID_W(HW_ID_W), .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .pushId       (pushId),
    .nextCur      (nextCur),
    .statId       (statId),
    .hostAddr     (hostAddr),
    .hostWrData   (hostWrData),
    .unitRegIdx   (unitRegIdx),
    .unitRegWrData(unitRegWrData),
    .curId        (curId),
    .stkFull      (stkFull),
    .stkEmpty     (stkEmpty),
    .stkTop       (stkTop),
    .hostRdData   (hostRdData),
    .irq          (irq),
    .unitEn       (unitEn),
    .argBus       (argBus),
    .spOut        (spOut)
  );

  // per-unit dispatch checks at the block boundary
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_chk
    logic [CALL_ID_W-1:0] reqId;
    assign reqId = unitCallId[g*CALL_ID_W +: CALL_ID_W];

    AST_HW_DISPATCH: assert property (@(posedge clk) disable iff (!rstN)
      unitEn[g] && unitCallReq[g] && unitCallHw[g] && !unitFinish[g] && !stkFull &&
      reqId != '0 && reqId <= CALL_ID_W'(NUM_UNITS)
      |=> curId == HW_ID_W'($past(reqId))); // R5

    AST_SWCALL_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      unitEn[g] && unitCallReq[g] && !unitCallHw[g] && !unitFinish[g] && !stkFull
      |=> irq && unitEn == '0); // R3
  end

endmodule

// File: tb/test_xcall_ctrl.sv
`timescale 1ns/1ps
module test_xcall_ctrl;
  localparam int NU = 4;
  localparam int NA = 4;
  localparam int DW = 32;
  localparam int IW = 8;
  localparam int AW = 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           hostWrEn = 1'b0;
  logic [AW-1:0]  hostAddr = '0;
  logic [DW-1:0]  hostWrData = '0;
  logic [DW-1:0]  hostRdData;
  logic           irq;
  logic [NU-1:0]  unitEn;
  logic [NU-1:0]  unitFinish = '0;
  logic [NU-1:0]  unitCallReq = '0;
  logic [NU-1:0]  unitCallHw = '0;
  logic [NU*IW-1:0] unitCallId = '0;
  logic           unitRegWrEn = 1'b0;
  logic [AW-1:0]  unitRegIdx = '0;
  logic [DW-1:0]  unitRegWrData = '0;
  logic [NA*DW-1:0] argBus;
  logic [DW-1:0]  spOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  xcall_ctrl i_xcall_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq), .unitEn(unitEn),
    .unitFinish(unitFinish), .unitCallReq(unitCallReq), .unitCallHw(unitCallHw),
    .unitCallId(unitCallId), .unitRegWrEn(unitRegWrEn), .unitRegIdx(unitRegIdx),
    .unitRegWrData(unitRegWrData), .argBus(argBus), .spOut(spOut)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWr(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = AW'(addr); hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
    #1;
  endtask

  task automatic hostRd(input int addr, output logic [DW-1:0] data);
    hostAddr = AW'(addr);
    #1;
    data = hostRdData;
  endtask

  task automatic unitCall(input int u, input logic hw, input logic [IW-1:0] id);
    @(negedge clk);
    unitCallReq[u] = 1'b1; unitCallHw[u] = hw; unitCallId[u*IW +: IW] = id;
    @(negedge clk);
    unitCallReq = '0; unitCallHw = '0; unitCallId = '0;
    #1;
  endtask

  task automatic unitDone(input int u);
    @(negedge clk);
    unitFinish[u] = 1'b1;
    @(negedge clk);
    unitFinish = '0;
    #1;
  endtask

  task automatic unitWr(input int idx, input logic [DW-1:0] data);
    @(negedge clk);
    unitRegWrEn = 1'b1; unitRegIdx = AW'(idx); unitRegWrData = data;
    @(negedge clk);
    unitRegWrEn = 1'b0;
    #1;
  endtask

  task automatic callHw(input int id);
    hostWr(0, DW'((id << 8) | 1));
  endtask

  task automatic clearIrq();
    hostWr(1, 32'h1);
  endtask

  task automatic testReset();
    logic [DW-1:0] v;
    chk("R1 enables", DW'(unitEn), 0);
    chk("R1 irq", DW'(irq), 0);
    hostRd(1, v); chk("R1 status", v, 0);
    hostRd(3, v); chk("R1 link", v, 0);
    chk("R1 sp", spOut, 0);
  endtask

  task automatic testSwCallsHw();
    logic [DW-1:0] v;
    hostWr(4, 32'h11);
    hostWr(2, 32'h1000);
    callHw(2);
    chk("R2 enable unit1", DW'(unitEn), 32'b0010);
    chk("R10 arg0 bus", argBus[31:0], 32'h11);
    chk("R10 sp bus", spOut, 32'h1000);
    hostRd(3, v); chk("R6 link is processor", v, 0);
    hostWr(5, 32'h99);
    hostRd(5, v); chk("R10 host write while unit active", v, 0);
    unitWr(4, 32'hAB);
    chk("R10 unit write arg0", argBus[31:0], 32'hAB);
    unitDone(1);
    chk("R8 unit disabled", DW'(unitEn), 0);
    chk("R8 irq", DW'(irq), 1);
    hostRd(1, v); chk("R8 status done", v, 32'h0201);
    repeat (3) @(negedge clk);
    chk("R8 irq sticky", DW'(irq), 1);
    clearIrq();
    chk("R8 irq cleared", DW'(irq), 0);
    hostRd(1, v); chk("R8 cause cleared", v, 32'h0200);
  endtask

  task automatic testHwCallsSw();
    logic [DW-1:0] v;
    callHw(1);
    chk("R2 enable unit0", DW'(unitEn), 32'b0001);
    unitCall(0, 1'b0, 8'h5A);
    chk("R3 unit suspended", DW'(unitEn), 0);
    chk("R3 irq", DW'(irq), 1);
    hostRd(1, v); chk("R3 status swcall", v, 32'h5A02);
    hostRd(3, v); chk("R6 link is unit0", v, 1);
    clearIrq();
    hostWr(0, 32'h2);
    chk("R4 resume unit0", DW'(unitEn), 32'b0001);
    chk("R4 no irq", DW'(irq), 0);
    unitDone(0);
    hostRd(1, v); chk("R8 status unit0 done", v, 32'h0101);
    clearIrq();
  endtask

  task automatic testHwCallsHw();
    logic [DW-1:0] v;
    callHw(1);
    unitCall(0, 1'b1, 8'd3);
    chk("R5 target enabled in one cycle", DW'(unitEn), 32'b0100);
    chk("R5 no irq on dispatch", DW'(irq), 0);
    hostRd(3, v); chk("R6 link is unit0", v, 1);
    unitDone(2);
    chk("R5 caller resumed in one cycle", DW'(unitEn), 32'b0001);
    chk("R5 no irq on return", DW'(irq), 0);
    unitDone(0);
    hostRd(1, v); chk("R8 status after hw chain", v, 32'h0101);
    clearIrq();
  endtask

  task automatic testNestedCross();
    logic [DW-1:0] v;
    callHw(1);
    unitCall(0, 1'b0, 8'h33);
    clearIrq();
    callHw(2);
    chk("R6 nested hw from sw", DW'(unitEn), 32'b0010);
    hostRd(3, v); chk("R6 link processor", v, 0);
    unitDone(1);
    chk("R6 back to processor", DW'(unitEn), 0);
    hostRd(1, v); chk("R6 status inner done", v, 32'h0201);
    clearIrq();
    hostRd(3, v); chk("R6 link unit0 waiting", v, 1);
    hostWr(0, 32'h2);
    chk("R6 outer caller resumed", DW'(unitEn), 32'b0001);
    unitDone(0);
    hostRd(1, v); chk("R6 outer done", v, 32'h0101);
    clearIrq();
  endtask

  task automatic testRecursion();
    logic [DW-1:0] v;
    callHw(1);
    for (int k = 0; k < 3; k++) unitCall(0, 1'b1, 8'd1);
    chk("R6 recursive enable", DW'(unitEn), 32'b0001);
    hostRd(1, v); chk("R7 no overflow yet", v & 32'h4, 0);
    unitCall(0, 1'b1, 8'd1);
    hostRd(1, v); chk("R7 overflow flag", v & 32'h4, 32'h4);
    chk("R7 call ignored", DW'(unitEn), 32'b0001);
    chk("R7 no irq", DW'(irq), 0);
    for (int k = 0; k < 3; k++) begin
      unitDone(0);
      chk("R6 recursive return", DW'(unitEn), 32'b0001);
      chk("R6 no irq mid unwind", DW'(irq), 0);
    end
    unitDone(0);
    chk("R6 final return irq", DW'(irq), 1);
    hostRd(1, v); chk("R7 status with overflow", v, 32'h0105);
    hostWr(1, 32'h5);
    hostRd(1, v); chk("R7 overflow cleared", v, 32'h0100);
    chk("R8 irq cleared", DW'(irq), 0);
  endtask

  task automatic testIgnored();
    logic [DW-1:0] v;
    callHw(1);
    unitCall(2, 1'b1, 8'd2);
    chk("R9 idle unit call", DW'(unitEn), 32'b0001);
    unitDone(3);
    chk("R9 idle unit finish", DW'(unitEn), 32'b0001);
    chk("R9 idle finish no irq", DW'(irq), 0);
    callHw(3);
    chk("R9 command while unit active", DW'(unitEn), 32'b0001);
    unitCall(0, 1'b1, 8'd0);
    chk("R9 hw id zero", DW'(unitEn), 32'b0001);
    unitCall(0, 1'b1, 8'd5);
    chk("R9 hw id too large", DW'(unitEn), 32'b0001);
    unitDone(0);
    chk("R9 first level still intact", DW'(irq), 1);
    clearIrq();
    callHw(0);
    chk("R9 host id zero", DW'(unitEn), 0);
    callHw(7);
    chk("R9 host id too large", DW'(unitEn), 0);
    hostWr(0, 32'h2);
    chk("R9 swdone with none waiting", DW'(unitEn), 0);
    chk("R9 swdone no irq", DW'(irq), 0);
    unitWr(4, 32'h77);
    hostRd(4, v); chk("R10 unit write while processor active", v, 32'hAB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    testSwCallsHw();
    testHwCallsSw();
    testHwCallsHw();
    testNestedCross();
    testRecursion();
    testIgnored();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule